// File: doc/BRIEF.md
# Paged Data Storage Overlay Controller

This block gives a microcontroller access to a 192-byte non-volatile data store, organised as three 64-byte pages, through four byte-wide special function registers. One register acts as a status port on read and as a command port on write. Two registers form a 16-bit address, and one register accepts data bytes. Data bytes collect in a 64-byte staging buffer. Timed erase and program commands then move the buffer contents into the store. Each timed command runs for a whole number of milliseconds, and the cycle count is derived from a clock-frequency parameter.

The store can be read only after a map command. That command overlays the store on the top of code space, so that code fetches and table reads in the window FF00H–FFBFH return store bytes. Every other code address, and every address while the store is unmapped, passes through to normal program memory. Each page has a protection input that blocks erase and program of that page.

The storage cells are modelled as a plain register array that resets to the erased value FFH.

Top module: `nvpage_ctrl`

## Requirements
- R1: Register select encoding is 0 = control/status, 1 = address low, 2 = address high, 3 = data. The address registers read back what was last written to them. Status reads as {mapped[7], 0000, done[2], err[1], busy[0]}. After reset the status is 00H and both address registers are 00H.
- R2: Any write to the control register clears err and done before the command acts. The err bit is then set again only if that command is rejected.
- R3: Command 09H sets the mapped state and command 0AH clears it. Both take effect only when no operation is running.
- R4: While mapped, a code read at FF00H–FFBFH returns store byte (address − FF00H). Page 0 is FF00H–FF3FH, page 1 is FF40H–FF7FH and page 2 is FF80H–FFBFH. Every other code read, and every code read while unmapped, returns the program-memory input.
- R5: A data-register write stores its byte in the staging buffer at offset address-low[5:0] and marks that offset as loaded. Data writes made while busy are ignored.
- R6: The target page for erase and program is address-low[7:6]. It is valid only when address-high is FFH and address-low[7:6] is below 3. Any other target rejects the command.
- R7: Command 11H (erase page) sets all 64 bytes of the target page to FFH after 2 ms. Other pages are not changed.
- R8: Command 12H (program page) writes only the loaded offsets of the target page after 2 ms and leaves the other bytes unchanged. The loaded marks clear when the command completes.
- R9: Command 13H (erase then program) takes 4 ms. The loaded offsets take the buffer bytes and every other byte of the page becomes FFH.
- R10: Command 14H (erase all) sets all three pages to FFH after 6 ms.
- R11: The busy bit stays high for exactly ms × CLK_HZ/1000 clock cycles after the command write. The done bit is set when it falls.
- R12: A command is rejected (err = 1, no effect) when it is an erase or program issued while unmapped, any command issued while busy, or an unknown code. A running operation is not disturbed by a rejected command.
- R13: When page_lock[p] is 1, erase and program commands on page p are rejected. Erase all is rejected while any page is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| page_lock | input | 3 | Per-page protection, 1 = locked |
| code_addr | input | 16 | Code-space read address |
| pm_rdata | input | 8 | Byte from normal program memory |
| code_rdata | output | 8 | Code-space read result |

## Verification
The bench loads sparse buffer bytes at scattered offsets on one page and then runs program-only, erase-then-program and erase on that page. Because program-only keeps old bytes and erase-then-program returns unloaded bytes to FFH, these runs tell the two commands apart. Neighbouring pages carry their own data, so that a page-select or erase-all fault shows up as a corrupted neighbour. Rejected-command patterns cover the following cases, each of which separates error gating from a silently executed command:
- a command issued during a running erase, with a data write made alongside it;
- an out-of-window target;
- a locked page;
- a command issued while unmapped.

// File: rtl/nvpage_pkg.sv
package nvpage_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int NUM_PAGES  = 3;
    localparam int PAGE_BYTES = 64;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int PG_W       = 2;
    localparam int TOTAL      = NUM_PAGES * PAGE_BYTES;
    localparam logic [DATA_W-1:0] WIN_HI = 8'hFF;
    localparam logic [DATA_W-1:0] ERASED = 8'hFF;

    // register select codes
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADRL = 2'd1;
    localparam logic [1:0] SEL_ADRH = 2'd2;
    localparam logic [1:0] SEL_DATA = 2'd3;

    // command codes
    localparam logic [DATA_W-1:0] CMD_MAP    = 8'h09;
    localparam logic [DATA_W-1:0] CMD_UNMAP  = 8'h0A;
    localparam logic [DATA_W-1:0] CMD_ERASE  = 8'h11;
    localparam logic [DATA_W-1:0] CMD_PROG   = 8'h12;
    localparam logic [DATA_W-1:0] CMD_ERPROG = 8'h13;
    localparam logic [DATA_W-1:0] CMD_ERALL  = 8'h14;

    typedef enum logic [1:0] {
        OP_ERASE  = 2'd0,
        OP_PROG   = 2'd1,
        OP_ERPROG = 2'd2,
        OP_ERALL  = 2'd3
    } op_e;

    typedef struct packed {
        logic            start;
        op_e             kind;
        logic [PG_W-1:0] page;
    } op_req_t;

    // duration of each timed operation in milliseconds
    function automatic int unsigned op_ms(op_e kind);
        case (kind)
            OP_ERASE:  return 2;
            OP_PROG:   return 2;
            OP_ERPROG: return 4;
            default:   return 6;
        endcase
    endfunction

endpackage

// File: rtl/nvpage_regs.sv
module nvpage_regs
    import nvpage_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           reg_sel,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_PAGES-1:0] page_lock,
    input  logic                 busy,
    input  logic                 op_done,
    output logic                 mapped,
    output logic                 buf_we,
    output logic [OFF_W-1:0]     buf_off,
    output logic [DATA_W-1:0]    buf_wdata,
    output op_req_t              req
);

    logic [DATA_W-1:0] adr_lo, adr_hi, data_q;
    logic              err_q, done_q, map_q;
    logic              cmd_wr;
    logic [PG_W-1:0]   tgt_page;
    logic              page_ok, lock_hit, any_lock;
    logic              cmd_bad, map_set, map_clr;

    assign cmd_wr   = reg_wr && (reg_sel == SEL_CTRL);
    assign tgt_page = adr_lo[DATA_W-1 -: PG_W];
    assign page_ok  = (adr_hi == WIN_HI) && (tgt_page < PG_W'(NUM_PAGES));
    assign lock_hit = |(page_lock & (NUM_PAGES'(1) << tgt_page));
    assign any_lock = |page_lock;
    assign mapped   = map_q;

    // command decode and acceptance
    always_comb begin
        cmd_bad  = 1'b0;
        map_set  = 1'b0;
        map_clr  = 1'b0;
        req      = '0;
        req.kind = OP_ERASE;
        req.page = tgt_page;
        if (cmd_wr) begin
            case (reg_wdata)
                CMD_MAP: begin
                    if (busy) cmd_bad = 1'b1;
                    else      map_set = 1'b1;
                end
                CMD_UNMAP: begin
                    if (busy) cmd_bad = 1'b1;
                    else      map_clr = 1'b1;
                end
                CMD_ERASE, CMD_PROG, CMD_ERPROG: begin
                    if (busy || !map_q || !page_ok || lock_hit) begin
                        cmd_bad = 1'b1;
                    end else begin
                        req.start = 1'b1;
                        req.kind  = (reg_wdata == CMD_ERASE) ? OP_ERASE :
                                    (reg_wdata == CMD_PROG)  ? OP_PROG  : OP_ERPROG;
                    end
                end
                CMD_ERALL: begin
                    if (busy || !map_q || any_lock) begin
                        cmd_bad = 1'b1;
                    end else begin
                        req.start = 1'b1;
                        req.kind  = OP_ERALL;
                    end
                end
                default: cmd_bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            adr_lo <= '0;
            adr_hi <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            map_q  <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == SEL_ADRL) adr_lo <= reg_wdata;
            if (reg_wr && reg_sel == SEL_ADRH) adr_hi <= reg_wdata;
            if (reg_wr && reg_sel == SEL_DATA) data_q <= reg_wdata;
            if (cmd_wr) begin
                err_q  <= cmd_bad;
                done_q <= 1'b0;
            end
            if (op_done) done_q <= 1'b1;
            if (map_set) map_q <= 1'b1;
            if (map_clr) map_q <= 1'b0;
        end
    end

    assign buf_we    = reg_wr && (reg_sel == SEL_DATA) && !busy;
    assign buf_off   = adr_lo[OFF_W-1:0];
    assign buf_wdata = reg_wdata;

    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {map_q, 4'b0000, done_q, err_q, busy};
            SEL_ADRL: reg_rdata = adr_lo;
            SEL_ADRH: reg_rdata = adr_hi;
            default:  reg_rdata = data_q;
        endcase
    end

    AST_CMD_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !op_done |=> !done_q); // R2
    AST_MAP_TAKES: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && reg_wdata == CMD_MAP && !busy |=> mapped); // R3
    AST_UNMAP_TAKES: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && reg_wdata == CMD_UNMAP && !busy |=> !mapped); // R3
    AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && busy |=> err_q); // R12

endmodule

// File: rtl/nvpage_timer.sv
module nvpage_timer
    import nvpage_pkg::*;
#(
    parameter int unsigned CLK_HZ = 12_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  kind,
    output logic busy,
    output logic done_pulse
);

    localparam int unsigned TICKS_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int          CNT_W    = $clog2(6 * TICKS_MS + 1);

    logic [CNT_W-1:0] cnt;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt    <= CNT_W'(op_ms(kind) * TICKS_MS - 1);
        end else if (busy_q) begin
            if (cnt == '0) busy_q <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign busy       = busy_q;
    assign done_pulse = busy_q && (cnt == '0);

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q); // R12
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        busy_q && !done_pulse |=> busy_q); // R11
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !busy_q); // R11

endmodule

// File: rtl/nvpage_store.sv
module nvpage_store
    import nvpage_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_we,
    input  logic [OFF_W-1:0]  buf_off,
    input  logic [DATA_W-1:0] buf_wdata,
    input  op_req_t           req,
    input  logic              commit,
    input  logic              mapped,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic [DATA_W-1:0] pm_rdata,
    output logic [DATA_W-1:0] code_rdata
);

    logic [DATA_W-1:0]     pbuf  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded;
    logic [DATA_W-1:0]     cells [TOTAL];
    op_e                   pend_kind;
    logic [PG_W-1:0]       pend_page;
    logic                  prog_kind;
    logic                  in_win;

    assign prog_kind = (pend_kind == OP_PROG) || (pend_kind == OP_ERPROG);

    // staging buffer with per-offset loaded marks
    always_ff @(posedge clk) begin
        if (rst) begin
            loaded <= '0;
            for (int b = 0; b < PAGE_BYTES; b++) pbuf[b] <= ERASED;
        end else begin
            if (buf_we) begin
                pbuf[buf_off]   <= buf_wdata;
                loaded[buf_off] <= 1'b1;
            end
            if (commit && prog_kind) loaded <= '0;
        end
    end

    // operation latched at start, applied at completion
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_kind <= OP_ERASE;
            pend_page <= '0;
        end else if (req.start) begin
            pend_kind <= req.kind;
            pend_page <= req.page;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TOTAL; i++) cells[i] <= ERASED;
        end else if (commit) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                for (int b = 0; b < PAGE_BYTES; b++) begin
                    case (pend_kind)
                        OP_ERASE: begin
                            if (pend_page == PG_W'(p)) cells[p*PAGE_BYTES+b] <= ERASED;
                        end
                        OP_PROG: begin
                            if (pend_page == PG_W'(p) && loaded[b])
                                cells[p*PAGE_BYTES+b] <= pbuf[b];
                        end
                        OP_ERPROG: begin
                            if (pend_page == PG_W'(p))
                                cells[p*PAGE_BYTES+b] <= loaded[b] ? pbuf[b] : ERASED;
                        end
                        default: cells[p*PAGE_BYTES+b] <= ERASED;
                    endcase
                end
            end
        end
    end

    // code-space overlay
    assign in_win = mapped && (code_addr[ADDR_W-1:DATA_W] == WIN_HI) &&
                    (code_addr[OFF_W+PG_W-1:OFF_W] < PG_W'(NUM_PAGES));

    always_comb begin
        if (in_win) code_rdata = cells[code_addr[OFF_W+PG_W-1:0]];
        else        code_rdata = pm_rdata;
    end

    AST_START_NEEDS_MAP: assert property (@(posedge clk) disable iff (rst)
        req.start |-> mapped); // R12
    AST_UNMAPPED_PASS: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> code_rdata == pm_rdata); // R4

endmodule

// File: rtl/nvpage_ctrl.sv
module nvpage_ctrl
    import nvpage_pkg::*;
#(
    parameter int unsigned CLK_HZ = 12_000_000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           reg_sel,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_PAGES-1:0] page_lock,
    input  logic [ADDR_W-1:0]    code_addr,
    input  logic [DATA_W-1:0]    pm_rdata,
    output logic [DATA_W-1:0]    code_rdata
);

    logic              busy, op_done, mapped, buf_we;
    logic [OFF_W-1:0]  buf_off;
    logic [DATA_W-1:0] buf_wdata;
    op_req_t           req;

    nvpage_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .page_lock (page_lock),
        .busy      (busy),
        .op_done   (op_done),
        .mapped    (mapped),
        .buf_we    (buf_we),
        .buf_off   (buf_off),
        .buf_wdata (buf_wdata),
        .req       (req)
    );

    nvpage_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (req.start),
        .kind       (req.kind),
        .busy       (busy),
        .done_pulse (op_done)
    );

    nvpage_store u_store (
        .clk        (clk),
        .rst        (rst),
        .buf_we     (buf_we),
        .buf_off    (buf_off),
        .buf_wdata  (buf_wdata),
        .req        (req),
        .commit     (op_done),
        .mapped     (mapped),
        .code_addr  (code_addr),
        .pm_rdata   (pm_rdata),
        .code_rdata (code_rdata)
    );

endmodule

// File: tb/nvpage_ctrl_bench.sv
module nvpage_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [2:0]  page_lock = 3'b000;
    logic [15:0] code_addr = 16'h0000;
    logic [7:0]  pm_rdata, code_rdata;
    int          nchk = 0;
    int          nerr = 0;
    bit          finished = 1'b0;

    // 4 clock cycles per millisecond: 2 ms = 8, 4 ms = 16, 6 ms = 24
    localparam int T2 = 8, T4 = 16, T6 = 24;

    always #2 clk = ~clk;
    assign pm_rdata = code_addr[7:0] ^ 8'h5A;

    nvpage_ctrl #(.CLK_HZ(4000)) u_nvpage_ctrl (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page_lock(page_lock),
        .code_addr(code_addr), .pm_rdata(pm_rdata), .code_rdata(code_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s; #1; v = reg_rdata;
    endtask

    task automatic chk_stat(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        rd(2'd0, v);
        chk(tag, v, exp);
    endtask

    task automatic chk_code(input string tag, input logic [15:0] a, input logic [7:0] exp);
        code_addr = a; #1;
        chk(tag, code_rdata, exp);
    endtask

    task automatic set_adr(input logic [15:0] a);
        wr(2'd1, a[7:0]);
        wr(2'd2, a[15:8]);
    endtask

    task automatic load(input logic [15:0] a, input logic [7:0] d);
        set_adr(a);
        wr(2'd3, d);
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] v;
        n = 0;
        rd(2'd0, v);
        while (v[0] && n < 200) begin
            n++;
            @(negedge clk);
            rd(2'd0, v);
        end
    endtask

    task automatic run_cmd(input string tag, input logic [7:0] cmd, input int cycles);
        int n;
        wr(2'd0, cmd);
        wait_idle(n);
        chk(tag, n, cycles);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk_stat("R1 reset status", 8'h00);
        rd(2'd1, v); chk("R1 reset adr low", v, 8'h00);
        rd(2'd2, v); chk("R1 reset adr high", v, 8'h00);
        chk_code("R4 unmapped passthrough", 16'hFF00, 8'hFF ^ 8'h00 ^ 8'hA5);
        set_adr(16'hFF43);
        rd(2'd1, v); chk("R1 adr low readback", v, 8'h43);
        rd(2'd2, v); chk("R1 adr high readback", v, 8'hFF);
    endtask

    task automatic t_map;
        wr(2'd0, 8'h09);
        chk_stat("R3 mapped status", 8'h80);
        chk_code("R4 page0 erased", 16'hFF00, 8'hFF);
        chk_code("R4 above window passthrough", 16'hFFC0, 8'hC0 ^ 8'h5A);
        chk_code("R4 below window passthrough", 16'hFE80, 8'h80 ^ 8'h5A);
    endtask

    task automatic t_program;
        load(16'hFF43, 8'hA1);
        load(16'hFF4A, 8'hB2);
        set_adr(16'hFF40);
        run_cmd("R11 program busy cycles", 8'h12, T2);
        chk_stat("R11 done after program", 8'h84);
        chk_code("R8 programmed byte 3", 16'hFF43, 8'hA1);
        chk_code("R5 programmed byte 10", 16'hFF4A, 8'hB2);
        chk_code("R8 unloaded byte stays", 16'hFF44, 8'hFF);
        load(16'hFF43, 8'h11);
        run_cmd("R8 second program cycles", 8'h12, T2);
        chk_code("R8 reprogram byte 3", 16'hFF43, 8'h11);
        chk_code("R8 older byte kept", 16'hFF4A, 8'hB2);
        load(16'hFF80, 8'h33);
        run_cmd("R8 page2 program cycles", 8'h12, T2);
        chk_code("R8 page2 byte", 16'hFF80, 8'h33);
    endtask

    task automatic t_erprog;
        load(16'hFF45, 8'h77);
        run_cmd("R9 erase-program cycles", 8'h13, T4);
        chk_code("R9 loaded byte", 16'hFF45, 8'h77);
        chk_code("R9 unloaded byte erased", 16'hFF4A, 8'hFF);
        chk_code("R9 page2 untouched", 16'hFF80, 8'h33);
    endtask

    task automatic t_erase;
        set_adr(16'hFF40);
        run_cmd("R7 erase cycles", 8'h11, T2);
        chk_code("R7 page1 erased", 16'hFF45, 8'hFF);
        chk_code("R7 page2 kept", 16'hFF80, 8'h33);
    endtask

    task automatic t_clear;
        chk_stat("R2 done before command", 8'h84);
        wr(2'd0, 8'h09);
        chk_stat("R2 done cleared by command", 8'h80);
        wr(2'd0, 8'h55);
        chk_stat("R12 unknown code error", 8'h82);
        wr(2'd0, 8'h09);
        chk_stat("R2 error cleared by command", 8'h80);
    endtask

    task automatic t_busy;
        int n;
        set_adr(16'hFF80);
        wr(2'd0, 8'h11);
        wr(2'd0, 8'h12);
        chk_stat("R12 command while busy", 8'h83);
        wr(2'd3, 8'h99);
        wait_idle(n);
        chk_stat("R11 done with error kept", 8'h86);
        chk_code("R12 running erase completed", 16'hFF80, 8'hFF);
        run_cmd("R5 program after ignored write", 8'h12, T2);
        chk_code("R5 busy data write ignored", 16'hFF80, 8'hFF);
    endtask

    task automatic t_target;
        set_adr(16'h1280);
        wr(2'd0, 8'h11);
        chk_stat("R6 high byte not FF", 8'h82);
        set_adr(16'hFFC0);
        wr(2'd0, 8'h11);
        chk_stat("R6 page 3 rejected", 8'h82);
    endtask

    task automatic t_lock;
        load(16'hFF40, 8'h42);
        run_cmd("R8 page1 program cycles", 8'h12, T2);
        page_lock = 3'b010;
        set_adr(16'hFF40);
        wr(2'd0, 8'h11);
        chk_stat("R13 locked page erase", 8'h82);
        chk_code("R13 locked page kept", 16'hFF40, 8'h42);
        wr(2'd0, 8'h14);
        chk_stat("R13 erase all with lock", 8'h82);
        set_adr(16'hFF00);
        run_cmd("R13 unlocked page cycles", 8'h11, T2);
        chk_stat("R13 unlocked page accepted", 8'h84);
        page_lock = 3'b000;
    endtask

    task automatic t_erall;
        load(16'hFF05, 8'h21);
        run_cmd("R8 page0 program cycles", 8'h12, T2);
        chk_code("R8 page0 byte", 16'hFF05, 8'h21);
        run_cmd("R10 erase all cycles", 8'h14, T6);
        chk_code("R10 page0 erased", 16'hFF05, 8'hFF);
        chk_code("R10 page1 erased", 16'hFF40, 8'hFF);
    endtask

    task automatic t_unmap;
        wr(2'd0, 8'h0A);
        chk_stat("R3 unmapped status", 8'h00);
        chk_code("R4 unmapped read", 16'hFF40, 8'h40 ^ 8'h5A);
        set_adr(16'hFF40);
        wr(2'd0, 8'h11);
        chk_stat("R12 erase while unmapped", 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_map;
        t_program;
        t_erprog;
        t_erase;
        t_clear;
        t_busy;
        t_target;
        t_lock;
        t_erall;
        t_unmap;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule